// File: doc/BRIEF.md
# Inter-Core Interrupt Hub

This block lets each core of an N-core cluster (four by default) post an interrupt to any other core and later find out, and retire, who posted it. Every core owns one command port: a valid strobe, a two-bit operation code and a core-number argument. A core can raise an interrupt on a target, ask whether a target already has something pending, ask which senders have interrupted it, and retire the interrupt from one named sender. The result of the two query operations lands in a readback register private to the core that asked.

The pending state is an N-by-N bit matrix indexed by target and sender. A target's interrupt line is the OR of its row, so several senders collapse into a single asserted line. The line drops only when every sender bit in that row has been retired. One command is executed per cycle. When several cores present commands together, the lowest-numbered core is accepted and the rest see their ready low and hold their request.

Top module: `xcore_irq_hub`

## Requirements
- R1: After a synchronous active-high reset every interrupt line is low, every readback register reads zero and no pending bit is set.
- R2: A command with op code 0 (raise) accepted from core S with argument T, where T differs from S, sets pending bit (T,S), and interrupt line T is high from the cycle after acceptance.
- R3: A raise whose argument equals the requesting core's own number changes no pending bit and no interrupt line.
- R4: A command with op code 1 (peek) accepted from core C with argument T loads C's readback with 1 if target T has any pending bit and with 0 otherwise, visible the cycle after acceptance.
- R5: A command with op code 2 (who) accepted from core C loads C's readback with a mask whose bit S is set exactly when sender S has an interrupt pending on C; upper bits are zero.
- R6: Raises to the same target from several senders merge into one asserted line, and the who mask then shows one bit per sender.
- R7: A command with op code 3 (ack) accepted from core C with argument S clears only pending bit (C,S); line C stays high while any other bit of row C remains set.
- R8: Among the cores with valid set, only the lowest-numbered one sees ready high and has its command executed in that cycle; the others see ready low and their commands have no effect.
- R9: Raise and ack commands leave every readback register unchanged, and a readback register changes only when its own core's peek or who is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NCORE | Per-core command request |
| cmd_op | input | 2*NCORE | Per-core op code, core c in bits [2c+1:2c] |
| cmd_arg | input | ID_W*NCORE | Per-core core-number argument, core c in bits [ID_W*c +: ID_W] |
| cmd_ready | output | NCORE | Per-core acceptance, high for the accepted core only |
| rd_data | output | RB_W*NCORE | Per-core readback register, core c in bits [RB_W*c +: RB_W] |
| irq_o | output | NCORE | Per-core interrupt line |

## Verification
The interesting collisions are two cores raising on the same target in one cycle, and a sender raising on a target while that target acknowledges or queries in the same cycle. The random phase drives all four ports at once with independent valid strobes, so both cases occur often; a directed case forces two simultaneous raises on one target. The bench predicts which core wins from the lowest-index rule, applies only that command to its own matrix, and then compares the ready vector, every interrupt line and every readback word against the prediction, so a stalled command that leaked into the state shows up as a mismatch.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_PEEK  = 2'd1,
        OP_WHO   = 2'd2,
        OP_ACK   = 2'd3
    } xirq_op_e;

    function automatic logic op_loads_rb(input xirq_op_e op);
        return (op == OP_PEEK) || (op == OP_WHO);
    endfunction

endpackage

// File: rtl/xirq_arbiter.sv
module xirq_arbiter #(
    parameter int N = 4,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    output logic            gnt_v,
    output logic [ID_W-1:0] gnt_id,
    output logic [N-1:0]    ready
);

    always_comb begin
        gnt_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt_id = ID_W'(i);
        end
        gnt_v = |req;
        ready = gnt_v ? (N'(1) << gnt_id) : '0;
    end

    assert_ready_single_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ready));

    assert_ready_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        (|ready) |-> (|(ready & req)));

    for (genvar i = 1; i < N; i++) begin : g_prio
        assert_prio_R8: assert property (@(posedge clk) disable iff (rst)
            (|req[i-1:0]) |-> !ready[i]);
    end

endmodule

// File: rtl/xirq_matrix.sv
module xirq_matrix
    import xirq_pkg::*;
#(
    parameter int N = 4,
    localparam int ID_W = $clog2(N),
    localparam int IDX_W = $clog2(N * N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gnt_v,
    input  logic [ID_W-1:0] gnt_id,
    input  xirq_op_e        op,
    input  logic [ID_W-1:0] arg,
    output logic [N*N-1:0]  pend_o,
    output logic [N-1:0]    irq_o
);

    logic do_raise, do_ack;
    assign do_raise = gnt_v && (op == OP_RAISE);
    assign do_ack   = gnt_v && (op == OP_ACK);

    for (genvar t = 0; t < N; t++) begin : g_tgt
        localparam logic [ID_W-1:0] TI = ID_W'(t);
        for (genvar s = 0; s < N; s++) begin : g_src
            localparam logic [ID_W-1:0] SI = ID_W'(s);
            if (t == s) begin : g_diag
                assign pend_o[t*N+s] = 1'b0;
            end else begin : g_cell
                logic bit_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        bit_q <= 1'b0;
                    else if (do_raise && arg == TI && gnt_id == SI)
                        bit_q <= 1'b1;
                    else if (do_ack && gnt_id == TI && arg == SI)
                        bit_q <= 1'b0;
                end
                assign pend_o[t*N+s] = bit_q;
            end
        end
        assign irq_o[t] = |pend_o[t*N +: N];
    end

    logic [IDX_W-1:0] set_idx, clr_idx;
    assign set_idx = IDX_W'(arg) * IDX_W'(N) + IDX_W'(gnt_id);
    assign clr_idx = IDX_W'(gnt_id) * IDX_W'(N) + IDX_W'(arg);

    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (do_raise && arg != gnt_id && int'(arg) < N)
        |=> (pend_o[$past(set_idx)] && irq_o[$past(arg)]));

    assert_self_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (do_raise && arg == gnt_id) |=> $stable(pend_o));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (do_ack && int'(arg) < N) |=> !pend_o[$past(clr_idx)]);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !gnt_v |=> $stable(pend_o));

endmodule

// File: rtl/xirq_readback.sv
module xirq_readback #(
    parameter int N = 4,
    parameter int RB_W = 32,
    localparam int ID_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ID_W-1:0]   gnt_id,
    input  logic [RB_W-1:0]   word,
    output logic [N*RB_W-1:0] rd_o
);

    logic [RB_W-1:0] rb_q [N];

    always_ff @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (rst)
                rb_q[c] <= '0;
            else if (load && gnt_id == ID_W'(c))
                rb_q[c] <= word;
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_out
        assign rd_o[c*RB_W +: RB_W] = rb_q[c];
    end

    assert_rb_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (rb_q[$past(gnt_id)] == $past(word)));

    assert_rb_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rd_o));

endmodule

// File: rtl/xcore_irq_hub.sv
module xcore_irq_hub
    import xirq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int RB_W = 32,
    localparam int ID_W = $clog2(NCORE)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCORE-1:0]      cmd_valid,
    input  logic [2*NCORE-1:0]    cmd_op,
    input  logic [ID_W*NCORE-1:0] cmd_arg,
    output logic [NCORE-1:0]      cmd_ready,
    output logic [RB_W*NCORE-1:0] rd_data,
    output logic [NCORE-1:0]      irq_o
);

    logic                   gnt_v;
    logic [ID_W-1:0]        gnt_id;
    xirq_op_e               op_g;
    logic [ID_W-1:0]        arg_g;
    logic [NCORE*NCORE-1:0] pend_w;
    logic [NCORE-1:0]       irq_w;
    logic                   peek_bit;
    logic [NCORE-1:0]       who_row;
    logic                   rb_load;
    logic [RB_W-1:0]        rb_word;

    xirq_arbiter #(.N(NCORE)) arb_i (
        .clk    (clk),
        .rst    (rst),
        .req    (cmd_valid),
        .gnt_v  (gnt_v),
        .gnt_id (gnt_id),
        .ready  (cmd_ready)
    );

    assign op_g  = xirq_op_e'(cmd_op[int'(gnt_id)*2 +: 2]);
    assign arg_g = cmd_arg[int'(gnt_id)*ID_W +: ID_W];

    xirq_matrix #(.N(NCORE)) mat_i (
        .clk    (clk),
        .rst    (rst),
        .gnt_v  (gnt_v),
        .gnt_id (gnt_id),
        .op     (op_g),
        .arg    (arg_g),
        .pend_o (pend_w),
        .irq_o  (irq_w)
    );

    assign peek_bit = (int'(arg_g) < NCORE) ? irq_w[arg_g] : 1'b0;
    assign who_row  = pend_w[int'(gnt_id)*NCORE +: NCORE];
    assign rb_load  = gnt_v && op_loads_rb(op_g);
    assign rb_word  = (op_g == OP_PEEK) ? RB_W'(peek_bit) : RB_W'(who_row);

    xirq_readback #(.N(NCORE), .RB_W(RB_W)) rb_i (
        .clk    (clk),
        .rst    (rst),
        .load   (rb_load),
        .gnt_id (gnt_id),
        .word   (rb_word),
        .rd_o   (rd_data)
    );

    assign irq_o = irq_w;

    assert_raise_keeps_rb_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt_v && (op_g == OP_RAISE || op_g == OP_ACK)) |=> $stable(rd_data));

    assert_who_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_v && op_g == OP_WHO)
        |=> (rd_data[int'($past(gnt_id))*RB_W +: RB_W] == RB_W'($past(who_row))));

endmodule

// File: tb/xcore_irq_hub_tb_top.sv
module xcore_irq_hub_tb_top;

    localparam int NC = 4;
    localparam int IW = 2;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] cmd_valid = '0;
    logic [2*NC-1:0]  cmd_op = '0;
    logic [IW*NC-1:0] cmd_arg = '0;
    logic [NC-1:0]    cmd_ready;
    logic [RW*NC-1:0] rd_data;
    logic [NC-1:0]    irq_o;

    xcore_irq_hub #(.NCORE(NC), .RB_W(RW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .cmd_ready (cmd_ready),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NC-1:0] m_pend [NC];
    logic [RW-1:0] m_rb [NC];

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int t = 0; t < NC; t++) r[t] = |m_pend[t];
        return r;
    endfunction

    function automatic int winner(input logic [NC-1:0] v);
        for (int i = 0; i < NC; i++) if (v[i]) return i;
        return -1;
    endfunction

    // compare all outputs against the model; called at a falling edge
    task automatic compare_all();
        chk("R2 R6 R7 irq", RW'(irq_o), RW'(exp_irq()));
        for (int c = 0; c < NC; c++)
            chk("R4 R5 R9 readback", rd_data[c*RW +: RW], m_rb[c]);
    endtask

    // drive one cycle of commands at a falling edge, check ready, update model
    task automatic issue(input logic [NC-1:0] v, input logic [2*NC-1:0] ops,
                         input logic [IW*NC-1:0] args);
        int g;
        int op;
        int a;
        cmd_valid = v; cmd_op = ops; cmd_arg = args;
        #1;
        g = winner(v);
        chk("R8 ready", RW'(cmd_ready), (g < 0) ? '0 : RW'(1) << g);
        if (g >= 0) begin
            op = int'(ops[g*2 +: 2]);
            a  = int'(args[g*IW +: IW]);
            case (op)
                0: if (a != g) m_pend[a][g] = 1'b1;
                1: m_rb[g] = RW'(|m_pend[a]);
                2: m_rb[g] = RW'(m_pend[g]);
                default: m_pend[g][a] = 1'b0;
            endcase
        end
        @(negedge clk);
        cmd_valid = '0;
        compare_all();
    endtask

    function automatic logic [2*NC-1:0] op_at(input int c, input int op);
        return (2*NC)'(op) << (2*c);
    endfunction

    function automatic logic [IW*NC-1:0] arg_at(input int c, input int a);
        return (IW*NC)'(a) << (IW*c);
    endfunction

    initial begin
        for (int c = 0; c < NC; c++) begin m_pend[c] = '0; m_rb[c] = '0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq after reset", RW'(irq_o), '0);
        for (int c = 0; c < NC; c++) chk("R1 readback after reset", rd_data[c*RW +: RW], '0);

        // R3: core 1 raises on itself
        issue(4'b0010, op_at(1, 0), arg_at(1, 1));
        chk("R3 self raise irq", RW'(irq_o), '0);

        // R6 R8: cores 0 and 2 raise on target 3 in the same cycle
        issue(4'b0101, op_at(0, 0) | op_at(2, 0), arg_at(0, 3) | arg_at(2, 3));
        chk("R2 target line up", RW'(irq_o), RW'(4'b1000));
        chk("R9 raise leaves readback", rd_data[0 +: RW], '0);
        issue(4'b0100, op_at(2, 0), arg_at(2, 3));
        issue(4'b1000, op_at(3, 2), '0);
        chk("R5 R6 who mask two senders", rd_data[3*RW +: RW], RW'(4'b0101));

        // R7: ack sender 0, line must stay for sender 2
        issue(4'b1000, op_at(3, 3), arg_at(3, 0));
        chk("R7 line held by other sender", RW'(irq_o), RW'(4'b1000));
        issue(4'b1000, op_at(3, 2), '0);
        chk("R7 R5 who after one ack", rd_data[3*RW +: RW], RW'(4'b0100));
        issue(4'b0010, op_at(1, 1), arg_at(1, 3));
        chk("R4 peek pending", rd_data[1*RW +: RW], RW'(1));
        issue(4'b1000, op_at(3, 3), arg_at(3, 2));
        chk("R7 line drops after last ack", RW'(irq_o), '0);
        issue(4'b0010, op_at(1, 1), arg_at(1, 3));
        chk("R4 peek empty", rd_data[1*RW +: RW], '0);

        // random mix of simultaneous commands from all cores
        for (int n = 0; n < 3000; n++) begin
            logic [NC-1:0] v;
            logic [2*NC-1:0] o;
            logic [IW*NC-1:0] a;
            v = NC'($urandom);
            o = (2*NC)'($urandom);
            a = (IW*NC)'($urandom);
            issue(v, o, a);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule